// File: doc/BRIEF.md
# Half-Duplex Collision Back-off Timer

This block decides how long a half-duplex Ethernet MAC waits before it tries a frame again after a collision. Each accepted collision samples a free-running 11-bit pseudo-random register. One bit of that sample is mixed with the matching bit of the running frame CRC. The sample is then cut down to the truncated binary exponential range for the current attempt. The block multiplies the result by the slot length in transmit clocks and counts it down. When the count expires it gives a one-cycle go-ahead for the retry.

The block also keeps the number of attempts for the current frame. A successful send clears it. The sixteenth collision on a frame ends the retries and raises a sticky excessive-collision flag, which only a software rearm pulse clears. The random register starts from a fixed seed on reset. Two stations reset on the same clock therefore pick the same delays until the CRC bit starts to differ, which happens once payload bytes are in the CRC.

Top module: `hd_backoff_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `backoff_busy`, `retry_go` and `excess_coll` are 0, and the random register holds the seed parameter `SEED` (default 11'h5A5).
- R2: The random register is 11 bits wide and advances on every clock edge out of reset. It shifts left by one, and the new bit 0 is the XOR of bits 10 and 8. It never holds zero.
- R3: The sampled random value is the random register with bit 2 XORed with `frame_crc[2]`. No other CRC bit changes the delay.
- R4: The n-th collision since the last clear (n = 1..15) keeps only the low min(n,10) bits of the sampled value. The result is the slot multiplier.
- R5: A collision sampled at one clock edge sets `backoff_busy` at that edge. The countdown is loaded with multiplier × `SLOT_CLKS` and drops by one per clock. `retry_go` rises multiplier × `SLOT_CLKS` + 1 edges after the sampling edge.
- R6: `retry_go` is high for exactly one cycle, and `backoff_busy` is already low in that cycle.
- R7: The 16th collision on a frame sets `excess_coll` at its sampling edge. It clears `backoff_busy` and no `retry_go` follows.
- R8: While `excess_coll` is set, collisions are ignored: `backoff_busy` stays low. The flag stays set until `sw_rearm`.
- R9: `sw_rearm` clears `excess_coll` and the attempt count. A collision in the same cycle is ignored, and the next collision counts as attempt 1.
- R10: A `send_ok` pulse clears the attempt count, so the next collision counts as attempt 1.
- R11: A collision that arrives during a countdown restarts it. The new delay uses the next attempt number and the random value at the new sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| coll_pulse | input | 1 | One-cycle collision indication |
| send_ok | input | 1 | One-cycle successful-transmit indication |
| frame_crc | input | 32 | Running CRC of the frame in flight |
| sw_rearm | input | 1 | Software re-enable after excessive collisions |
| backoff_busy | output | 1 | Back-off countdown in progress |
| retry_go | output | 1 | One-cycle retry permission |
| excess_coll | output | 1 | Sticky excessive-collision status |

## Verification
The bench runs one frame through all fifteen retried attempts and measures every delay to the exact cycle. This shows the widening mask separately at each attempt up to the cap of ten bits. A second run alternates CRC words that differ only in bit 2 against words with every other bit set. This separates a correct single-bit mix from a mix that uses the wrong bit or more than one. Further cases show that each clearing path returns the next collision to a one-bit mask: a send success, a rearm, and a rearm that collides in the same cycle. The excessive path shows that no retry follows and that collisions arriving while the flag is set are ignored. A collision during a running countdown shows that the count restarts.

// File: rtl/bo_pkg.sv
package bo_pkg;
  // cap an attempt number at the exponent limit
  function automatic int unsigned exp_limit(input int unsigned n, input int unsigned cap);
    return (n < cap) ? n : cap;
  endfunction
endpackage

// File: rtl/bo_lfsr.sv
module bo_lfsr #(
  parameter int W     = 11,
  parameter int TAP_A = 10,
  parameter int TAP_B = 8,
  parameter logic [W-1:0] SEED = 11'h5A5
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] value
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= SEED;
    else     q <= {q[W-2:0], q[TAP_A] ^ q[TAP_B]};
  end

  assign value = q;

  // R2: a maximal sequence never reaches the all-zero lock-up state
  p_lfsr_nonzero_r2: assert property (@(posedge clk) disable iff (rst) q != '0);
  // R2: each step is a left shift
  p_lfsr_shift_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> q[W-1:1] == $past(q[W-2:0]));
endmodule

// File: rtl/bo_attempts.sv
module bo_attempts #(
  parameter int MAX_COLL = 15,
  localparam int ATT_W = $clog2(MAX_COLL + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             coll,
  input  logic             success,
  input  logic             rearm,
  output logic [ATT_W:0]   next_idx,
  output logic             accept,
  output logic             overflow,
  output logic             excess
);
  logic [ATT_W-1:0] att;

  assign next_idx = {1'b0, att} + 1'b1;
  assign accept   = coll && !excess && !rearm;
  assign overflow = accept && (next_idx > (ATT_W+1)'(MAX_COLL));

  always_ff @(posedge clk) begin
    if (rst) begin
      att    <= '0;
      excess <= 1'b0;
    end else if (rearm) begin
      att    <= '0;
      excess <= 1'b0;
    end else if (overflow) begin
      att    <= '0;
      excess <= 1'b1;
    end else if (accept) begin
      att    <= next_idx[ATT_W-1:0];
    end else if (success) begin
      att    <= '0;
    end
  end

  // R8: the flag is sticky until rearm
  p_excess_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    excess && !rearm |=> excess);
  // R9: rearm always clears the flag
  p_rearm_clears_r9: assert property (@(posedge clk) disable iff (rst)
    rearm |=> !excess);
  // R7: the count never passes the collision limit
  p_att_bound_r7: assert property (@(posedge clk) disable iff (rst)
    att <= ATT_W'(MAX_COLL));
endmodule

// File: rtl/bo_countdown.sv
module bo_countdown #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             abort,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             go
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
      go   <= 1'b0;
    end else if (abort) begin
      cnt  <= '0;
      busy <= 1'b0;
      go   <= 1'b0;
    end else if (load) begin
      cnt  <= load_val;
      busy <= 1'b1;
      go   <= 1'b0;
    end else if (busy) begin
      if (cnt == '0) begin
        busy <= 1'b0;
        go   <= 1'b1;
      end else begin
        cnt  <= cnt - 1'b1;
        go   <= 1'b0;
      end
    end else begin
      go <= 1'b0;
    end
  end

  // R6: the retry strobe lasts one cycle
  p_go_single_r6: assert property (@(posedge clk) disable iff (rst) go |=> !go);
  // R6: the strobe follows the end of the busy window
  p_go_after_busy_r6: assert property (@(posedge clk) disable iff (rst)
    go |-> !busy && $past(busy));
  // R5: the count falls by one per clock while running
  p_count_steps_r5: assert property (@(posedge clk) disable iff (rst)
    busy && cnt != '0 && !load && !abort |=> busy && cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/hd_backoff_gen.sv
module hd_backoff_gen #(
  parameter int            LFSR_W    = 11,
  parameter logic [10:0]   SEED      = 11'h5A5,
  parameter int            CRC_W     = 32,
  parameter int            MIX_BIT   = 2,
  parameter int            EXP_CAP   = 10,
  parameter int            SLOT_CLKS = 128,
  parameter int            MAX_COLL  = 15,
  localparam int           ATT_W     = $clog2(MAX_COLL + 2),
  localparam int           MAX_LOAD  = ((1 << EXP_CAP) - 1) * SLOT_CLKS,
  localparam int           CNT_W     = $clog2(MAX_LOAD + 1)
) (
  input  logic             tx_clk,
  input  logic             rst,
  input  logic             coll_pulse,
  input  logic             send_ok,
  input  logic [CRC_W-1:0] frame_crc,
  input  logic             sw_rearm,
  output logic             backoff_busy,
  output logic             retry_go,
  output logic             excess_coll
);
  import bo_pkg::*;

  logic [LFSR_W-1:0]  rnd_raw;
  logic [LFSR_W-1:0]  rnd_mixed;
  logic [ATT_W:0]     next_idx;
  logic               accept;
  logic               overflow;
  logic [EXP_CAP-1:0] mask;
  logic [EXP_CAP-1:0] mult;
  logic [CNT_W-1:0]   load_val;

  bo_lfsr #(.W(LFSR_W), .TAP_A(LFSR_W-1), .TAP_B(LFSR_W-3), .SEED(SEED[LFSR_W-1:0])) u_lfsr (
    .clk(tx_clk), .rst(rst), .value(rnd_raw)
  );

  bo_attempts #(.MAX_COLL(MAX_COLL)) u_att (
    .clk(tx_clk), .rst(rst), .coll(coll_pulse), .success(send_ok), .rearm(sw_rearm),
    .next_idx(next_idx), .accept(accept), .overflow(overflow), .excess(excess_coll)
  );

  // fold the frame CRC into one bit of the random sample
  always_comb begin
    rnd_mixed = rnd_raw;
    rnd_mixed[MIX_BIT] = rnd_raw[MIX_BIT] ^ frame_crc[MIX_BIT];
  end

  // mask bit i is kept once the attempt number exceeds i
  for (genvar i = 0; i < EXP_CAP; i++) begin : g_mask
    assign mask[i] = (next_idx > (ATT_W+1)'(i));
  end

  assign mult     = rnd_mixed[EXP_CAP-1:0] & mask;
  assign load_val = CNT_W'(mult) * CNT_W'(SLOT_CLKS);

  bo_countdown #(.CNT_W(CNT_W)) u_cd (
    .clk(tx_clk), .rst(rst), .load(accept && !overflow), .abort(overflow),
    .load_val(load_val), .busy(backoff_busy), .go(retry_go)
  );

  initial begin
    if (EXP_CAP > LFSR_W) $error("EXP_CAP exceeds LFSR width");
    if (exp_limit(MAX_COLL, EXP_CAP) > EXP_CAP) $error("bad exponent cap");
  end

  // R7: no countdown or strobe while the excess flag is set
  p_excess_quiet_r7: assert property (@(posedge tx_clk) disable iff (rst)
    excess_coll |-> !backoff_busy && !retry_go);
  // R8: an ignored collision starts nothing
  p_ignored_coll_r8: assert property (@(posedge tx_clk) disable iff (rst)
    coll_pulse && excess_coll && !sw_rearm |=> !backoff_busy);
  // R5: an accepted collision below the limit starts a countdown
  p_coll_starts_r5: assert property (@(posedge tx_clk) disable iff (rst)
    accept && !overflow |=> backoff_busy);
endmodule

// File: tb/test_hd_backoff_gen.sv
module test_hd_backoff_gen;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT = 2;
  localparam logic [10:0] SEED = 11'h5A5;

  logic tx_clk = 1'b0;
  logic rst = 1'b1;
  logic coll_pulse = 1'b0;
  logic send_ok = 1'b0;
  logic [31:0] frame_crc = '0;
  logic sw_rearm = 1'b0;
  logic backoff_busy, retry_go, excess_coll;

  int total = 0;
  int bad = 0;
  int att = 0;
  int cycles = 0;
  logic [10:0] m;

  hd_backoff_gen #(.SLOT_CLKS(SLOT), .SEED(SEED)) i_hd_backoff_gen (
    .tx_clk(tx_clk), .rst(rst), .coll_pulse(coll_pulse), .send_ok(send_ok),
    .frame_crc(frame_crc), .sw_rearm(sw_rearm), .backoff_busy(backoff_busy),
    .retry_go(retry_go), .excess_coll(excess_coll)
  );

  always #(CLK_PERIOD/2) tx_clk = ~tx_clk;

  // reference random register built from R2
  always @(posedge tx_clk) begin
    if (rst) m <= SEED;
    else     m <= {m[9:0], m[10] ^ m[8]};
    cycles <= cycles + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_delay(input logic [10:0] r, input logic [31:0] crc, input int n);
    logic [10:0] v;
    int e;
    v = r;
    v[2] = r[2] ^ crc[2];
    e = (n < 10) ? n : 10;
    return int'(v & 11'((1 << e) - 1)) * SLOT;
  endfunction

  // one accepted collision, then measure the delay up to the retry strobe
  task automatic coll_wait(input logic [31:0] crc, input string req);
    int L;
    int n;
    @(negedge tx_clk);
    att++;
    L = exp_delay(m, crc, att);
    coll_pulse = 1'b1; frame_crc = crc;
    @(negedge tx_clk);
    coll_pulse = 1'b0;
    n = 1;
    chk(backoff_busy == 1'b1, "R5 busy after collision", int'(backoff_busy), 1);
    while (!retry_go && n < 5000) begin
      @(negedge tx_clk);
      n++;
    end
    chk(n == L + 2, req, n, L + 2);
    chk(backoff_busy == 1'b0, "R6 busy low during strobe", int'(backoff_busy), 0);
    @(negedge tx_clk);
    chk(retry_go == 1'b0, "R6 single-cycle strobe", int'(retry_go), 0);
  endtask

  initial begin
    repeat (190000) @(posedge tx_clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge tx_clk);
    chk(!backoff_busy && !retry_go && !excess_coll, "R1 outputs in reset",
        int'({backoff_busy, retry_go, excess_coll}), 0);
    rst = 1'b0;
    @(negedge tx_clk);
    chk(!backoff_busy && !retry_go && !excess_coll, "R1 outputs after reset",
        int'({backoff_busy, retry_go, excess_coll}), 0);

    // R2 R4 R5: a full frame of fifteen retries, CRC contributes nothing
    for (int k = 0; k < 15; k++) coll_wait(32'h0, "R4 R2 delay for attempt");

    // R7: sixteenth collision
    @(negedge tx_clk);
    coll_pulse = 1'b1;
    @(negedge tx_clk);
    coll_pulse = 1'b0;
    chk(excess_coll == 1'b1, "R7 excess set", int'(excess_coll), 1);
    chk(backoff_busy == 1'b0, "R7 no countdown", int'(backoff_busy), 0);
    begin
      int seen = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge tx_clk);
        if (retry_go) seen++;
      end
      chk(seen == 0, "R7 no retry after excess", seen, 0);
    end

    // R8: collisions ignored while flagged
    coll_pulse = 1'b1;
    @(negedge tx_clk);
    coll_pulse = 1'b0;
    chk(backoff_busy == 1'b0, "R8 collision ignored", int'(backoff_busy), 0);
    chk(excess_coll == 1'b1, "R8 flag sticky", int'(excess_coll), 1);

    // R9: rearm with a same-cycle collision
    sw_rearm = 1'b1; coll_pulse = 1'b1;
    @(negedge tx_clk);
    sw_rearm = 1'b0; coll_pulse = 1'b0;
    chk(excess_coll == 1'b0, "R9 rearm clears flag", int'(excess_coll), 0);
    chk(backoff_busy == 1'b0, "R9 same-cycle collision ignored", int'(backoff_busy), 0);
    att = 0;
    coll_wait(32'h0, "R9 attempt count restarted");
    coll_wait(32'h0, "R9 second attempt after rearm");

    // R3: CRC bit 2 against all other bits
    for (int k = 0; k < 12; k++)
      coll_wait((k % 2) ? 32'h0000_0004 : 32'hFFFF_FFFB, "R3 CRC mix");

    // R10: success clears the attempt count
    @(negedge tx_clk);
    send_ok = 1'b1;
    @(negedge tx_clk);
    send_ok = 1'b0;
    att = 0;
    for (int k = 0; k < 4; k++) coll_wait(32'h0000_0004, "R10 attempts after success");

    // R11: a collision during a countdown restarts it
    att = 0;
    @(negedge tx_clk);
    send_ok = 1'b1;
    @(negedge tx_clk);
    send_ok = 1'b0;
    for (int k = 0; k < 3; k++) coll_wait(32'h0, "R11 lead-in attempts");
    @(negedge tx_clk);
    att++;
    coll_pulse = 1'b1;
    @(negedge tx_clk);
    coll_pulse = 1'b0;
    coll_wait(32'h0, "R11 restarted countdown");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule